// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a device virtual address into a physical address by reading two levels of translation entries from memory. A request carries the virtual address, an access kind (read or write) and a choice between two entry layouts. The bits above both table levels choose one of several root tables. The walker reads the first-level entry from that root table and then the leaf entry from the table that entry names. It answers with either a physical address or a fault with a cause code.

Memory is reached through a single 64-bit read port that has one request outstanding at a time. The page size (4 KiB or 16 KiB) and the virtual address width are parameters, and the number of root tables follows from them (at most four). The root table bases and their enable bits come in as configuration inputs. One translation is in flight at a time. While a walk is running, the request side stays closed.

Top module: `tt_walker`

## Requirements
- R1: With BPL = PAGE_SHIFT-3, the root number is va[PAGE_SHIFT+2*BPL +: TBL_BITS], the first-level entry is read at root_base + 8*va[PAGE_SHIFT+BPL +: BPL], and the leaf entry is read at table_base + 8*va[PAGE_SHIFT +: BPL]. With the defaults (4 KiB, 32-bit va) these are va[31:30], va[29:21] and va[20:12].
- R2: In layout 1 (req_fmt2=0), the table or page address of an entry is entry[35:12] placed at address bits 35:12, with all other address bits zero.
- R3: In layout 2 (req_fmt2=1), the table or page address of an entry is entry[37:10] shifted left by 4, which places it at address bits 41:14, with the low 14 bits zero.
- R4: On success, rsp_pa is the leaf page address OR-ed with va[PAGE_SHIFT-1:0], and rsp_cause is 0 after exactly two memory reads.
- R5: An entry whose bit 0 is clear, the all-zero entry included, answers with rsp_cause=2 (not present). At the first level this happens after one memory read; at the leaf it happens after two.
- R6: For a leaf entry, layout 1 treats bit 8 as no-read and bit 7 as no-write; layout 2 treats bit 3 as no-read and bit 2 as no-write. A read to a no-read leaf, or a write to a no-write leaf, answers with rsp_cause=3. The bits of the other layout are ignored.
- R7: A root number whose root_en bit is 0 answers with rsp_cause=1 without issuing any memory read.
- R8: For a successful layout 2 walk, rsp_nocache carries leaf bit 1. It is 0 for every layout 1 walk. On any fault, rsp_pa and rsp_nocache are 0 and rsp_fault is 1; rsp_fault is 0 exactly when rsp_cause is 0.
- R9: req_ready is low from the cycle after a request is accepted until the response. rsp_valid is a single-cycle pulse, and req_ready is high in the cycle after it.
- R10: At most one memory read is outstanding. mem_req_valid, once raised, stays high with a stable mem_addr until mem_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base_flat | input | NROOT*42 | Root table byte addresses, root n at bits [n*42 +: 42] |
| root_en | input | NROOT | Enable bit per root table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_fmt2 | input | 1 | 1 = layout 2 entries, 0 = layout 1 |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 42 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry value |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Walk failed |
| rsp_cause | output | 2 | 0 ok, 1 root disabled, 2 not present, 3 permission |
| rsp_pa | output | 42 | Physical address |
| rsp_nocache | output | 1 | Leaf no-cache state (layout 2 only) |

## Verification
The bound checker watches, on every cycle, the closed request window and the single-cycle response pulse. It also checks the held memory request and that only one read is outstanding. For each response it checks the number of reads a walk used for its cause: none for a disabled root, two on success. It also checks the cleared address and no-cache state on faults and the zero no-cache state for layout 1. Only the scenarios can show that the index fields, the two address decodings, the offset merge and the permission bit positions give the right physical address and cause. For that they compare every response with a walk that the bench computes over its own memory image.

// File: rtl/tt_walker_pkg.sv
package tt_walker_pkg;
  localparam int PA_W  = 42;
  localparam int PTE_W = 64;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_ROOT_OFF = 2'd1,
    CAUSE_ABSENT   = 2'd2,
    CAUSE_PERM     = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROOT, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_RESP
  } state_e;

  // Physical address named by an entry in either layout.
  function automatic logic [PA_W-1:0] pte_base(input logic [PTE_W-1:0] e, input logic fmt2);
    if (fmt2) return {e[37:10], 14'b0};
    return {6'b0, e[35:12], 12'b0};
  endfunction

  // Access permission of a leaf entry.
  function automatic logic pte_allows(input logic [PTE_W-1:0] e, input logic fmt2, input logic wr);
    logic no_rd, no_wr;
    no_rd = fmt2 ? e[3] : e[8];
    no_wr = fmt2 ? e[2] : e[7];
    return wr ? !no_wr : !no_rd;
  endfunction
endpackage

// File: rtl/tt_index_split.sv
module tt_index_split #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int TBL_BITS   = 2,
  parameter int RSEL_W     = 2,
  localparam int BPL       = PAGE_SHIFT - 3
) (
  input  logic [VA_W-1:0]       va,
  output logic [RSEL_W-1:0]     root_sel,
  output logic [BPL-1:0]        l1_idx,
  output logic [BPL-1:0]        l2_idx,
  output logic [PAGE_SHIFT-1:0] page_off
);
  assign l1_idx   = va[PAGE_SHIFT+BPL +: BPL];
  assign l2_idx   = va[PAGE_SHIFT +: BPL];
  assign page_off = va[PAGE_SHIFT-1:0];

  generate
    if (TBL_BITS > 0) begin : g_multi_root
      assign root_sel = va[PAGE_SHIFT+2*BPL +: TBL_BITS];
    end else begin : g_single_root
      assign root_sel = '0;
    end
  endgenerate
endmodule

// File: rtl/tt_pte_decode.sv
module tt_pte_decode
  import tt_walker_pkg::*;
(
  input  logic [PTE_W-1:0] entry,
  input  logic             fmt2,
  input  logic             is_write,
  output logic             present,
  output logic [PA_W-1:0]  base_addr,
  output logic             perm_ok,
  output logic             nocache
);
  logic unused_entry_bits;

  assign present   = entry[0];
  assign base_addr = pte_base(entry, fmt2);
  assign perm_ok   = pte_allows(entry, fmt2, is_write);
  assign nocache   = fmt2 & entry[1];
  assign unused_entry_bits = ^{entry[63:38], entry[9], entry[6:4]};
endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tt_walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  localparam int BPL       = PAGE_SHIFT - 3,
  localparam int SPAN      = VA_W - PAGE_SHIFT - 2*BPL,
  localparam int TBL_BITS  = (SPAN > 0) ? SPAN : 0,
  localparam int NROOT     = 1 << TBL_BITS,
  localparam int RSEL_W    = (TBL_BITS > 0) ? TBL_BITS : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NROOT*PA_W-1:0] root_base_flat,
  input  logic [NROOT-1:0]      root_en,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic                  req_write,
  input  logic                  req_fmt2,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_addr,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_data,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [1:0]            rsp_cause,
  output logic [PA_W-1:0]       rsp_pa,
  output logic                  rsp_nocache
);
  state_e              state;
  logic [VA_W-1:0]     va_q;
  logic                wr_q, fmt2_q;
  logic [PA_W-1:0]     tbl_q, pa_q;
  logic                nc_q;
  cause_e              cause_q;

  // Named events for the checker.
  logic accept, mem_fire, l1_done, l2_done;

  logic [RSEL_W-1:0]     root_sel;
  logic [BPL-1:0]        l1_idx, l2_idx, cur_idx;
  logic [PAGE_SHIFT-1:0] page_off;
  logic                  e_present, e_perm_ok, e_nocache;
  logic [PA_W-1:0]       e_base, root_base;

  tt_index_split #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .TBL_BITS(TBL_BITS), .RSEL_W(RSEL_W)
  ) split_i (
    .va(va_q), .root_sel(root_sel), .l1_idx(l1_idx), .l2_idx(l2_idx), .page_off(page_off)
  );

  tt_pte_decode dec_i (
    .entry(mem_rsp_data), .fmt2(fmt2_q), .is_write(wr_q),
    .present(e_present), .base_addr(e_base), .perm_ok(e_perm_ok), .nocache(e_nocache)
  );

  assign req_ready     = (state == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_fire      = mem_req_valid && mem_req_ready;
  assign l1_done       = (state == ST_L1_WAIT) && mem_rsp_valid;
  assign l2_done       = (state == ST_L2_WAIT) && mem_rsp_valid;

  assign cur_idx   = (state == ST_L1_REQ) ? l1_idx : l2_idx;
  assign mem_addr  = tbl_q + {{(PA_W-BPL-3){1'b0}}, cur_idx, 3'b000};
  assign root_base = root_base_flat[root_sel*PA_W +: PA_W];

  assign rsp_valid   = (state == ST_RESP);
  assign rsp_cause   = cause_q;
  assign rsp_fault   = (cause_q != CAUSE_NONE);
  assign rsp_pa      = pa_q;
  assign rsp_nocache = nc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      fmt2_q  <= 1'b0;
      tbl_q   <= '0;
      pa_q    <= '0;
      nc_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          va_q    <= req_va;
          wr_q    <= req_write;
          fmt2_q  <= req_fmt2;
          pa_q    <= '0;
          nc_q    <= 1'b0;
          cause_q <= CAUSE_NONE;
          state   <= ST_ROOT;
        end
        ST_ROOT: if (root_en[root_sel]) begin
          tbl_q <= root_base;
          state <= ST_L1_REQ;
        end else begin
          cause_q <= CAUSE_ROOT_OFF;
          state   <= ST_RESP;
        end
        ST_L1_REQ: if (mem_fire) state <= ST_L1_WAIT;
        ST_L1_WAIT: if (l1_done) begin
          if (!e_present) begin
            cause_q <= CAUSE_ABSENT;
            state   <= ST_RESP;
          end else begin
            tbl_q <= e_base;
            state <= ST_L2_REQ;
          end
        end
        ST_L2_REQ: if (mem_fire) state <= ST_L2_WAIT;
        ST_L2_WAIT: if (l2_done) begin
          state <= ST_RESP;
          if (!e_present)      cause_q <= CAUSE_ABSENT;
          else if (!e_perm_ok) cause_q <= CAUSE_PERM;
          else begin
            pa_q <= e_base | {{(PA_W-PAGE_SHIFT){1'b0}}, page_off};
            nc_q <= e_nocache;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tt_walker_chk.sv
module tt_walker_chk #(
  parameter int PA_W = 42
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            req_fmt2,
  input logic            accept,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_rsp_valid,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_nocache
);
  logic [1:0] reads;
  logic       outstanding;
  logic       fmt2_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reads       <= '0;
      outstanding <= 1'b0;
      fmt2_seen   <= 1'b0;
    end else begin
      if (accept) begin
        reads     <= '0;
        fmt2_seen <= req_fmt2;
      end else if (mem_req_valid && mem_req_ready) begin
        reads <= reads + 2'd1;
      end
      if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
      else if (mem_rsp_valid)             outstanding <= 1'b0;
    end
  end

  assert_closed_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_closed_until_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_valid) |=> !req_ready);
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && outstanding));
  assert_root_off_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 2'd1) |-> (reads == 2'd0));
  assert_ok_two_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 2'd0) |-> (reads == 2'd2));
  assert_l1_absent_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 2'd2) |-> (reads != 2'd0));
  assert_fault_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_nocache));
  assert_fmt1_nocache_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fmt2_seen) |-> !rsp_nocache);
endmodule

bind tt_walker tt_walker_chk #(.PA_W(tt_walker_pkg::PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_fmt2(req_fmt2),
  .accept(accept), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_pa(rsp_pa),
  .rsp_nocache(rsp_nocache)
);

// File: tb/tt_walker_tb_top.sv
`timescale 1ns/1ps
module tt_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4*42-1:0] root_base_flat;
  logic [3:0]      root_en;
  logic            req_valid = 1'b0, req_write = 1'b0, req_fmt2 = 1'b0;
  logic [31:0]     req_va = '0;
  logic            req_ready;
  logic            mem_req_valid, mem_req_ready = 1'b0;
  logic [41:0]     mem_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            rsp_valid, rsp_fault, rsp_nocache;
  logic [1:0]      rsp_cause;
  logic [41:0]     rsp_pa;

  tt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .root_base_flat(root_base_flat), .root_en(root_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_fmt2(req_fmt2),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_pa(rsp_pa), .rsp_nocache(rsp_nocache)
  );

  typedef struct {
    logic [41:0] pa;
    logic [1:0]  cause;
    logic        nc;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] mem[logic [41:0]];
  logic [41:0] rb[4];
  int          errors = 0, checks = 0, cyc = 0, ncnt = 0, reads_seen = 0;
  logic        pend = 1'b0;
  logic [41:0] pend_addr = '0;
  bit          done = 0;

  assign root_base_flat = {rb[3], rb[2], rb[1], rb[0]};

  function automatic logic [63:0] rd(input logic [41:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Reference walk from the requirements.
  function automatic exp_t model(input logic [31:0] va, input bit wr, input bit f2, input string tag);
    exp_t e;
    logic [63:0] e1, e2;
    logic [41:0] t;
    bit nr, nw;
    e.pa = '0; e.cause = 2'd0; e.nc = 1'b0; e.reads = 0; e.tag = tag;
    if (!root_en[va[31:30]]) begin e.cause = 2'd1; return e; end
    e1 = rd(rb[va[31:30]] + {30'd0, va[29:21], 3'b0}); e.reads = 1;
    if (!e1[0]) begin e.cause = 2'd2; return e; end
    t = f2 ? {e1[37:10], 14'b0} : {6'b0, e1[35:12], 12'b0};
    e2 = rd(t + {30'd0, va[20:12], 3'b0}); e.reads = 2;
    if (!e2[0]) begin e.cause = 2'd2; return e; end
    nr = f2 ? e2[3] : e2[8];
    nw = f2 ? e2[2] : e2[7];
    if (wr ? nw : nr) begin e.cause = 2'd3; return e; end
    e.pa = (f2 ? {e2[37:10], 14'b0} : {6'b0, e2[35:12], 12'b0}) | {30'd0, va[11:0]};
    e.nc = f2 ? e2[1] : 1'b0;
    return e;
  endfunction

  // Memory model and scoreboard monitor.
  always @(negedge clk) begin
    ncnt++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rd(pend_addr);
      pend = 1'b0;
    end
    mem_req_ready = (ncnt % 3) != 1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend = 1'b1;
      pend_addr = mem_addr;
      reads_seen++;
    end
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check("R9", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "pa", {22'd0, rsp_pa}, {22'd0, e.pa});
        check(e.tag, "cause", {62'd0, rsp_cause}, {62'd0, e.cause});
        check(e.tag, "fault", {63'd0, rsp_fault}, {63'd0, (e.cause != 2'd0)});
        check(e.tag, "nocache", {63'd0, rsp_nocache}, {63'd0, e.nc});
        check(e.tag, "mem reads", reads_seen, e.reads);
      end
      reads_seen = 0;
    end
  end

  task automatic run(input logic [31:0] va, input bit wr, input bit f2, input string tag);
    sb_q.push_back(model(va, wr, f2, tag));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_va = va; req_write = wr; req_fmt2 = f2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R9"}, "req_ready after accept", {63'd0, req_ready}, 64'd0);
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check({tag, " R9"}, "req_ready after rsp", {63'd0, req_ready}, 64'd1);
    check({tag, " R9"}, "rsp_valid pulse", {63'd0, rsp_valid}, 64'd0);
  endtask

  function automatic logic [31:0] mkva(input int r, input int i1, input int i2, input int off);
    return {r[1:0], i1[8:0], i2[8:0], off[11:0]};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    rb[0] = 42'h0010_0000; rb[1] = 42'h0020_0000;
    rb[2] = 42'h0070_0000; rb[3] = 42'h0030_0000;
    root_en = 4'b1011;
    // Layout 1 tables under root 0, first-level slot 5.
    mem[42'h0010_0000 + 5*8] = 64'h0040_0001;
    mem[42'h0040_0000 + 7*8]  = 64'hABCD_E001;
    mem[42'h0040_0000 + 8*8]  = 64'h1111_1000 | (64'd1 << 7) | 64'd1;
    mem[42'h0040_0000 + 9*8]  = 64'h1234_5000 | (64'd1 << 8) | 64'd1;
    mem[42'h0040_0000 + 11*8] = 64'h2222_2000 | 64'h0A | 64'd1;
    mem[42'h0040_0000 + 12*8] = 64'h3333_3000;
    // Layout 2 tables under root 1, first-level slot 3.
    mem[42'h0020_0000 + 3*8] = (64'h0050_0000 >> 4) | 64'd1;
    mem[42'h0050_0000 + 2*8] = (64'h3_4567_C000 >> 4) | 64'h2 | 64'd1;
    mem[42'h0050_0000 + 3*8] = (64'h0_9ABC_0000 >> 4) | 64'h4 | 64'd1;
    mem[42'h0050_0000 + 4*8] = (64'h1_0000_4000 >> 4) | 64'h8 | 64'd1;
    mem[42'h0050_0000 + 5*8] = (64'h2_0000_8000 >> 4) | (64'd3 << 7) | 64'd1;
    // Boundary under root 3.
    mem[42'h0030_0000 + 511*8] = 64'h0060_0001;
    mem[42'h0060_0000 + 511*8] = 64'hF_FFFF_F001;

    repeat (3) @(negedge clk);
    check("R9", "reset req_ready", {63'd0, req_ready}, 64'd1);
    check("R9", "reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R10", "reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    rst_n = 1'b1;

    run(mkva(0, 5, 7, 12'h123), 0, 0, "R1 R2 R4 layout1 read");
    run(mkva(0, 5, 7, 12'h000), 1, 0, "R4 layout1 write");
    run(mkva(0, 5, 8, 12'h010), 1, 0, "R6 layout1 no-write write");
    run(mkva(0, 5, 8, 12'h010), 0, 0, "R6 layout1 no-write read");
    run(mkva(0, 5, 9, 12'h020), 0, 0, "R6 layout1 no-read read");
    run(mkva(0, 5, 9, 12'h020), 1, 0, "R6 layout1 no-read write");
    run(mkva(0, 5, 10, 12'h0), 0, 0, "R5 leaf zero");
    run(mkva(0, 5, 12, 12'h0), 0, 0, "R5 leaf valid clear");
    run(mkva(0, 5, 11, 12'h456), 0, 0, "R8 R6 layout1 ignores layout2 bits");
    run(mkva(0, 6, 1, 12'h0), 0, 0, "R5 first level zero");
    run(mkva(2, 5, 7, 12'h0), 0, 0, "R7 root disabled");
    run(mkva(1, 3, 2, 12'hABC), 0, 1, "R3 R8 layout2 nocache read");
    run(mkva(1, 3, 3, 12'h0), 1, 1, "R6 layout2 no-write write");
    run(mkva(1, 3, 4, 12'h0), 0, 1, "R6 layout2 no-read read");
    run(mkva(1, 3, 4, 12'h7FF), 1, 1, "R6 layout2 no-read write");
    run(mkva(1, 3, 5, 12'h001), 0, 1, "R6 layout2 ignores layout1 bits");
    run(mkva(0, 5, 7, 12'h0), 0, 1, "R3 layout1 table read as layout2");
    run(mkva(3, 511, 511, 12'hFFF), 0, 0, "R1 R4 top indices");
    run(mkva(1, 3, 2, 12'h0), 1, 1, "R10 back-to-back walk");

    done = 1;
    report();
    $finish;
  end
endmodule